// File: doc/BRIEF.md
# Cache Event Performance Counter Unit

This block counts cache activity for a single cache slice. It holds a bank of 32-bit counters. Each counter has an 8-bit selector that picks the event it counts: the free-running clock, or one of six one-cycle event pulses supplied by the slice. Software reaches every counter and control field through a simple 32-bit register port. It can preload or zero any counter, start and stop counters one at a time or all together, and join an even/odd pair into a 64-bit count.

Each counter reports overflow through a status register whose bits are cleared by writing ones. A per-counter mode raises the status bit whenever bit 31 changes, so a counter can run freely and software only has to read it twice per wrap. A single level interrupt goes high while any enabled status bit is set. The register port is a plain single-cycle strobe port with no back-pressure: every write lands at the next clock edge, and read data appears one cycle after the read strobe. The event pulse input is a sampled bit vector with no handshake.

Top module: `cache_event_pmu`

## Requirements
- R1: After reset, every counter, every count and interrupt enable, the gang and status masks, the read data output and `irq` are all 0.
- R2: An enabled counter advances by one on each clock edge where its selector matches. Selector 0x01 matches every cycle. Selector 0x20+k matches when `ev_pulse[k]` is 1, for k from 0 to 5. Any other selector never matches.
- R3: Bit 0 of the global control register at 0x500 is the global count enable. While it is 0, no counter advances.
- R4: Writing ones to 0x508 sets count enable bits and writing ones to 0x50C clears them. Zero bits leave the mask unchanged, and a read of either address returns the mask. The interrupt enable mask uses 0x510 (set) and 0x514 (clear) in the same way.
- R5: Counter n's value at 0x420+8n, its selector at 0x220+8n (bits 7:0) and its control word at 0x120+8n can all be written and read back. A counter write takes priority over an increment in the same cycle.
- R6: Setting bit n (n odd) of the gang register at 0x718 makes counter n count only the wraps of counter n-1, in the same cycle as the wrap, and ignore its own selector. Even bits of the gang register are not stored and read as 0.
- R7: When a counter's bit in 0x96C is 0, its status bit in 0x740 (bit n) is set only when the counter wraps from all ones to zero.
- R8: When a counter's bit in 0x96C is 1, its status bit is set on every change of counter bit 31, in either direction.
- R9: Writing ones to 0x740 clears those status bits. A status bit that is set in the same cycle as it is cleared ends up set.
- R10: `irq` is 1 exactly while some status bit and its interrupt enable bit are both 1.
- R11: Writing 1 to bit 1 of 0x500 clears all counters, both enable masks, the gang mask and the status mask in one cycle. Selectors, control words and the toggle mask keep their values. Bit 1 always reads as 0.
- R12: Read data is registered and valid the cycle after `reg_rd`. Addresses that map to no register read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| ev_pulse | input | 6 | One-cycle cache event pulses; bit k is event code 0x20+k |
| irq | output | 1 | Level interrupt: enabled overflow pending |

## Verification
Three pairs of events can fall in the same clock edge. A status clear can meet a new overflow on the same counter. A software write to a counter can meet a matching event pulse. An even counter's wrap can meet the carry into its ganged odd partner. The bench provokes each one by holding a chosen event pulse high across the very cycle in which the register write is issued, or by preloading a counter one step below its wrap point. It then judges the outcome by reading back the status mask and both halves of the pair: the status bit must remain set, the written value must win, and the odd half must have advanced exactly once while its own selected event was ignored.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  // Selector codes
  localparam logic [7:0] EV_CYCLES = 8'h01;
  localparam logic [7:0] EV_FIRST  = 8'h20;

  // Register offsets (software decodes these)
  localparam int OFS_GCTL  = 'h500;
  localparam int OFS_ENSET = 'h508;
  localparam int OFS_ENCLR = 'h50C;
  localparam int OFS_IESET = 'h510;
  localparam int OFS_IECLR = 'h514;
  localparam int OFS_GANG  = 'h718;
  localparam int OFS_OVS   = 'h740;
  localparam int OFS_TOG   = 'h96C;
  localparam int OFS_CNT   = 'h420;
  localparam int OFS_CCTL  = 'h120;
  localparam int OFS_SEL   = 'h220;
  localparam int STRIDE    = 8;

  // Mask with every odd index below n set
  function automatic logic [31:0] odd_bits(int n);
    logic [31:0] m;
    m = '0;
    for (int i = 1; i < n; i += 2) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmu_evt_match.sv
module pmu_evt_match
  import pmu_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int NUM_EV = 6
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_EV-1:0] ev,
  output logic              hit
);
  always_comb begin
    hit = (sel == SEL_W'(EV_CYCLES));
    for (int i = 0; i < NUM_EV; i++) begin
      if (sel == SEL_W'(EV_FIRST) + SEL_W'(i) && ev[i]) hit = 1'b1;
    end
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap,
  output logic         msb_flip
);
  logic step;
  assign step = inc & ~wr & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else if (wr)  value <= wdata;
    else if (step) value <= value + {{(W-1){1'b0}}, 1'b1};
  end

  assign wrap     = step & (&value);
  assign msb_flip = step & (&value[W-2:0]);

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> value == $past(value) + {{(W-1){1'b0}}, 1'b1});
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr && !clr) |=> $stable(value));
  // R5
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> value == $past(wdata));
endmodule

// File: rtl/cache_event_pmu.sv
module cache_event_pmu
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 8,
  parameter int NUM_EV  = 6,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_EV-1:0] ev_pulse,
  output logic              irq
);
  localparam int DW = 32;
  localparam logic [NUM_CNT-1:0] ODD_MASK = NUM_CNT'(odd_bits(NUM_CNT));

  logic                 glb_en;
  logic [NUM_CNT-1:0]   cnt_en, int_en, gang, tog, ovs;
  logic [NUM_CNT-1:0]   inc, wrap, flip, hit, ovf_evt, cnt_wr;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel;
  logic [NUM_CNT-1:0][DW-1:0]    cctl;
  logic [DW-1:0]        rd_val;
  logic [NUM_CNT-1:0]   wmask;

  assign wmask = reg_wdata[NUM_CNT-1:0];

  logic wr_gctl, wr_enset, wr_enclr, wr_ieset, wr_ieclr, wr_gang, wr_ovs, wr_tog, soft_clr;
  assign wr_gctl  = reg_wr && reg_addr == ADDR_W'(OFS_GCTL);
  assign wr_enset = reg_wr && reg_addr == ADDR_W'(OFS_ENSET);
  assign wr_enclr = reg_wr && reg_addr == ADDR_W'(OFS_ENCLR);
  assign wr_ieset = reg_wr && reg_addr == ADDR_W'(OFS_IESET);
  assign wr_ieclr = reg_wr && reg_addr == ADDR_W'(OFS_IECLR);
  assign wr_gang  = reg_wr && reg_addr == ADDR_W'(OFS_GANG);
  assign wr_ovs   = reg_wr && reg_addr == ADDR_W'(OFS_OVS);
  assign wr_tog   = reg_wr && reg_addr == ADDR_W'(OFS_TOG);
  assign soft_clr = wr_gctl && reg_wdata[1];

  // Global and mask registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      cnt_en <= '0;
      int_en <= '0;
      gang   <= '0;
      tog    <= '0;
      ovs    <= '0;
    end else begin
      if (wr_gctl) glb_en <= reg_wdata[0];
      if (wr_tog)  tog    <= wmask;
      if (soft_clr) begin
        cnt_en <= '0;
        int_en <= '0;
        gang   <= '0;
        ovs    <= '0;
      end else begin
        if (wr_enset)      cnt_en <= cnt_en | wmask;
        else if (wr_enclr) cnt_en <= cnt_en & ~wmask;
        if (wr_ieset)      int_en <= int_en | wmask;
        else if (wr_ieclr) int_en <= int_en & ~wmask;
        if (wr_gang)       gang   <= wmask & ODD_MASK;
        ovs <= (ovs & ~(wr_ovs ? wmask : '0)) | ovf_evt;
      end
    end
  end

  // Per-counter slices
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_slice
    logic wr_sel, wr_cctl;
    assign wr_sel  = reg_wr && reg_addr == ADDR_W'(OFS_SEL  + STRIDE * n);
    assign wr_cctl = reg_wr && reg_addr == ADDR_W'(OFS_CCTL + STRIDE * n);
    assign cnt_wr[n] = reg_wr && reg_addr == ADDR_W'(OFS_CNT + STRIDE * n);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel[n]  <= '0;
        cctl[n] <= '0;
      end else begin
        if (wr_sel)  sel[n]  <= reg_wdata[SEL_W-1:0];
        if (wr_cctl) cctl[n] <= reg_wdata;
      end
    end

    pmu_evt_match #(.SEL_W(SEL_W), .NUM_EV(NUM_EV)) u_match (
      .sel(sel[n]), .ev(ev_pulse), .hit(hit[n])
    );

    if (n % 2 == 1) begin : g_odd
      assign inc[n] = glb_en & cnt_en[n] & (gang[n] ? wrap[n-1] : hit[n]);

      // R6
      gang_ignores_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gang[n] && !wrap[n-1] && !cnt_wr[n] && !soft_clr) |=> $stable(cnt[n]));
    end else begin : g_even
      assign inc[n] = glb_en & cnt_en[n] & hit[n];
    end

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr(cnt_wr[n]),
      .wdata(CNT_W'(reg_wdata)), .inc(inc[n]),
      .value(cnt[n]), .wrap(wrap[n]), .msb_flip(flip[n])
    );

    assign ovf_evt[n] = tog[n] ? flip[n] : wrap[n];
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    if (reg_addr == ADDR_W'(OFS_GCTL)) rd_val = DW'(glb_en);
    if (reg_addr == ADDR_W'(OFS_ENSET) || reg_addr == ADDR_W'(OFS_ENCLR)) rd_val = DW'(cnt_en);
    if (reg_addr == ADDR_W'(OFS_IESET) || reg_addr == ADDR_W'(OFS_IECLR)) rd_val = DW'(int_en);
    if (reg_addr == ADDR_W'(OFS_GANG)) rd_val = DW'(gang);
    if (reg_addr == ADDR_W'(OFS_OVS))  rd_val = DW'(ovs);
    if (reg_addr == ADDR_W'(OFS_TOG))  rd_val = DW'(tog);
    for (int n = 0; n < NUM_CNT; n++) begin
      if (reg_addr == ADDR_W'(OFS_CNT  + STRIDE * n)) rd_val = DW'(cnt[n]);
      if (reg_addr == ADDR_W'(OFS_SEL  + STRIDE * n)) rd_val = DW'(sel[n]);
      if (reg_addr == ADDR_W'(OFS_CCTL + STRIDE * n)) rd_val = cctl[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  assign irq = |(ovs & int_en);

  // R3
  glb_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !reg_wr) |=> $stable(cnt));
  // R7
  no_spurious_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0) |=> ((ovs & ~$past(ovs)) == '0));
  // R9
  ovs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ovs && (&wmask) && ovf_evt == '0) |=> ovs == '0);
  // R11
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cnt_en == '0 && int_en == '0 && gang == '0 && ovs == '0));
endmodule

// File: tb/test_cache_event_pmu.sv
module test_cache_event_pmu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [5:0]  ev_pulse;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cache_event_pmu i_cache_event_pmu (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_pulse(ev_pulse), .irq(irq)
  );

  function automatic logic [11:0] a_cnt(int n);  return 12'(12'h420 + 8 * n); endfunction
  function automatic logic [11:0] a_sel(int n);  return 12'(12'h220 + 8 * n); endfunction
  function automatic logic [11:0] a_cctl(int n); return 12'(12'h120 + 8 * n); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rdchk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(logic [5:0] v);
    ev_pulse = v;
    @(posedge clk); #1;
    ev_pulse = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_cnt [6];
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0; ev_pulse = '0;
    repeat (3) @(posedge clk); #1;
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset contents
    for (int n = 0; n < 8; n++) rdchk("R1 counter", a_cnt(n), 0);
    rdchk("R1 enables", 12'h508, 0);
    rdchk("R1 status", 12'h740, 0);

    // R4: set/clear enable masks
    wr(12'h508, 32'h0F);
    wr(12'h508, 32'h00);
    rdchk("R4 set mask", 12'h508, 32'h0F);
    wr(12'h50C, 32'h03);
    rdchk("R4 clr reads mask", 12'h50C, 32'h0C);
    rdchk("R4 set reads mask", 12'h508, 32'h0C);
    wr(12'h50C, 32'hFF);
    wr(12'h510, 32'h81);
    rdchk("R4 int mask", 12'h514, 32'h81);
    wr(12'h514, 32'hFF);

    // R12: unmapped addresses
    rdchk("R12 unmapped", 12'h004, 0);
    rdchk("R12 misaligned", 12'h424, 0);

    // R2/R3: cycle event between global enable and disable writes
    wr(a_sel(0), 32'h01);
    wr(a_cnt(0), 0);
    wr(12'h508, 32'h01);
    wr(12'h500, 32'h1);
    repeat (5) begin @(posedge clk); #1; end
    wr(12'h500, 32'h0);
    rdchk("R2 cycle count", a_cnt(0), 6);
    repeat (3) pulse(6'h3F);
    rdchk("R3 global stop", a_cnt(0), 6);

    // R2: random event pulses
    for (int k = 0; k < 6; k++) begin
      wr(a_sel(k), 32'h20 + k);
      wr(a_cnt(k), 0);
      exp_cnt[k] = 0;
    end
    wr(a_sel(6), 32'h30); wr(a_cnt(6), 0);
    wr(a_sel(7), 32'h26); wr(a_cnt(7), 0);
    wr(12'h508, 32'hFF);
    wr(12'h500, 32'h1);
    for (int c = 0; c < 300; c++) begin
      logic [5:0] v;
      v = 6'($urandom());
      for (int k = 0; k < 6; k++) exp_cnt[k] += {31'b0, v[k]};
      pulse(v);
    end
    wr(12'h500, 32'h0);
    for (int k = 0; k < 6; k++) rdchk("R2 random event count", a_cnt(k), exp_cnt[k]);
    rdchk("R2 unknown code", a_cnt(6), 0);
    rdchk("R2 code past range", a_cnt(7), 0);

    // R5: write beats increment; selector and control readback
    wr(12'h500, 32'h1);
    ev_pulse = 6'h20;
    wr(a_cnt(5), 32'd100);
    ev_pulse = '0;
    wr(12'h500, 32'h0);
    rdchk("R5 write wins", a_cnt(5), 32'd100);
    rdchk("R5 selector", a_sel(5), 32'h25);
    wr(a_cctl(3), 32'hABCD1234);
    rdchk("R5 control word", a_cctl(3), 32'hABCD1234);

    // R6: chained pair 0/1
    wr(12'h50C, 32'hFF);
    wr(12'h740, 32'hFF);
    wr(a_sel(0), 32'h20);
    wr(a_sel(1), 32'h21);
    wr(a_cnt(0), 32'hFFFFFFFE);
    wr(a_cnt(1), 32'd5);
    wr(12'h718, 32'h03);
    rdchk("R6 gang even bit dropped", 12'h718, 32'h02);
    wr(12'h508, 32'h03);
    wr(12'h510, 32'h01);
    wr(12'h500, 32'h1);
    pulse(6'h01);
    pulse(6'h02);
    pulse(6'h01);
    wr(12'h500, 32'h0);
    rdchk("R6 low half wrapped", a_cnt(0), 0);
    rdchk("R6 high half carried once", a_cnt(1), 32'd6);
    rdchk("R7 wrap sets status", 12'h740, 32'h01);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(12'h740, 32'h01);
    rdchk("R9 status cleared", 12'h740, 0);
    chk("R10 irq low", {31'b0, irq}, 0);

    // R8/R7: bit-31 toggle mode vs wrap-only mode
    wr(12'h718, 32'h0);
    wr(12'h96C, 32'h04);
    wr(a_sel(2), 32'h22); wr(a_cnt(2), 32'h7FFFFFFF);
    wr(a_sel(3), 32'h23); wr(a_cnt(3), 32'h7FFFFFFF);
    wr(12'h508, 32'h0C);
    wr(12'h500, 32'h1);
    pulse(6'h0C);
    rdchk("R8 rising msb flags; R7 no wrap no flag", 12'h740, 32'h04);
    wr(12'h740, 32'h04);
    wr(a_cnt(2), 32'hFFFFFFFF);
    pulse(6'h04);
    rdchk("R8 falling msb flags", 12'h740, 32'h04);
    rdchk("R8 counter wrapped", a_cnt(2), 0);

    // R9: clear and set in the same cycle
    wr(12'h740, 32'hFF);
    wr(a_sel(4), 32'h24);
    wr(a_cnt(4), 32'hFFFFFFFF);
    wr(12'h508, 32'h10);
    ev_pulse = 6'h10;
    wr(12'h740, 32'h10);
    ev_pulse = '0;
    rdchk("R9 set beats clear", 12'h740, 32'h10);

    // R11: soft reset
    wr(12'h510, 32'h10);
    wr(12'h718, 32'h02);
    wr(12'h500, 32'h2);
    rdchk("R11 reset bit reads 0", 12'h500, 0);
    rdchk("R11 status", 12'h740, 0);
    rdchk("R11 count enables", 12'h508, 0);
    rdchk("R11 int enables", 12'h510, 0);
    rdchk("R11 gang", 12'h718, 0);
    rdchk("R11 counter", a_cnt(5), 0);
    rdchk("R11 selector kept", a_sel(4), 32'h24);
    rdchk("R11 toggle kept", 12'h96C, 32'h04);
    chk("R11 irq", {31'b0, irq}, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule